// File: doc/BRIEF.md
# Floating-Point Status Flag Unit

This block holds the 32-bit floating-point status word of a processor and keeps it current as single-precision operations complete. An external arithmetic unit reports, on a one-cycle operation strobe, which exception conditions the operation raised. These are invalid, divide-by-zero, overflow, underflow and inexact, plus separate indications for a denormal input or a denormal output. The unit then rebuilds the cause field, updates the sticky flags and the summary bit, and raises a one-cycle exception request whenever an enabled cause appears.

On the same strobe the unit also updates the processor's zero, sign and overflow condition flags. It derives them from the operation result, or from the outcome code when the operation was a compare. Software rewrites the word through a write strobe. The rounding-mode field is exported continuously so the arithmetic unit can use it.

The update selector picks one of three actions each cycle. HOLD keeps the word. OPER applies an operation update and is taken whenever `op_valid` is high. SOFT applies a software write and is taken when `sw_wr` is high and `op_valid` is low.

Top module: `fpsf_unit`

Status word layout: rounding mode [1:0]; cause bits [7:2] ordered invalid(2), overflow(3), divide-by-zero(4), underflow(5), inexact(6), unimplemented(7); denormal-flush control [8]; enables [14:10] ordered invalid(10), overflow(11), divide-by-zero(12), underflow(13), inexact(14); sticky flags [30:26] in the same order starting at 26; summary [31]. The remaining bits are plain storage.

## Requirements
- R1: After reset the status word, the rounding mode, the three condition flags and the exception request are all 0.
- R2: An operation update first clears every cause bit [7:2], then sets each IEEE cause bit [6:2] whose indication is asserted. The word is visible on `status_word` in the cycle after the strobe.
- R3: An operation sets the sticky flag for an asserted indication only when that condition's enable bit is 0. Operations never clear sticky flags.
- R4: A denormal input or output indication sets the unimplemented cause bit 7 when the flush control bit 8 is 0. It sets nothing when bit 8 is 1.
- R5: After every update, bit 31 equals the OR of the sticky flags [30:26].
- R6: `exc_req` is high for exactly the cycle after a strobe whose new cause field ANDed with the enables is nonzero. The unimplemented cause counts as always enabled. `exc_vector` reads 21.
- R7: For a non-compare operation, `cond_zero` is set when result bits [30:0] are all zero, so negative zero counts as zero. `cond_sign` takes result bit 31, and `cond_ovf` keeps its previous value.
- R8: For a compare, the outcome code selects the flags: 0 (greater) clears all three, 1 (equal) sets only zero, 2 (less) sets only sign, 3 (unordered) sets only overflow.
- R9: A software write loads bits [1:0] and [30:8] from the written data and sets bits [7:2] to their old value ANDed with the data, so causes can only be cleared. It recomputes bit 31 from the new flags and ignores written bit 31.
- R10: `round_mode` always equals status bits [1:0]: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R11: When `sw_wr` and `op_valid` are high in the same cycle, the write is ignored and only the operation update takes effect.
- R12: Without a strobe, the condition flags and the status word hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation completed this cycle |
| op_is_cmp | input | 1 | Completed operation is a compare |
| op_result | input | 32 | Result bits of a non-compare operation |
| cmp_outcome | input | 2 | Compare outcome code (see R8) |
| ind_invalid | input | 1 | Invalid-operation indication |
| ind_divzero | input | 1 | Divide-by-zero indication |
| ind_overflow | input | 1 | Overflow indication |
| ind_underflow | input | 1 | Underflow indication |
| ind_inexact | input | 1 | Inexact indication |
| ind_denorm_in | input | 1 | Denormal operand seen |
| ind_denorm_out | input | 1 | Denormal result produced |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| status_word | output | 32 | Current status word |
| round_mode | output | 2 | Rounding-mode field |
| cond_zero | output | 1 | Zero condition flag |
| cond_sign | output | 1 | Sign condition flag |
| cond_ovf | output | 1 | Overflow condition flag |
| exc_req | output | 1 | One-cycle exception request |
| exc_vector | output | 8 | Exception vector number |

## Verification
A corrupted status register shows on `status_word` and `round_mode` at once, because both are read straight from it. Every check after a strobe therefore catches a wrong cause, flag or summary bit one cycle after the offending update. A sticky flag that is lost or set wrongly also stays visible in later words, so the error persists across the next checks. A fault in the exception logic shows as `exc_req` missing, appearing with a disabled cause, or lasting two cycles; the bench examines the cycle after the strobe and the one after that.

// File: rtl/fpsf_pkg.sv
package fpsf_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned N_IEEE    = 5;
    localparam int unsigned RM_LSB    = 0;
    localparam int unsigned RM_W      = 2;
    localparam int unsigned CAUSE_LSB = 2;
    localparam int unsigned CAUSE_W   = N_IEEE + 1;
    localparam int unsigned UNIMP_BIT = CAUSE_LSB + N_IEEE;
    localparam int unsigned FLUSH_BIT = 8;
    localparam int unsigned EN_LSB    = 10;
    localparam int unsigned FLAG_LSB  = 26;
    localparam int unsigned SUM_BIT   = 31;

    typedef enum logic [1:0] {
        CMP_GT = 2'd0,
        CMP_EQ = 2'd1,
        CMP_LT = 2'd2,
        CMP_UN = 2'd3
    } cmp_res_e;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_PINF = 2'd2,
        RND_NINF = 2'd3
    } rnd_e;

    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_OPER = 2'd1,
        UPD_SOFT = 2'd2
    } upd_e;
endpackage

// File: rtl/fpsf_cause_gen.sv
module fpsf_cause_gen
    import fpsf_pkg::*;
(
    input  logic [WORD_W-1:0] cur_word,
    input  logic [N_IEEE-1:0] ieee_ind,
    input  logic              denorm_in,
    input  logic              denorm_out,
    output logic [WORD_W-1:0] nxt_word,
    output logic              raise
);
    logic [N_IEEE-1:0] enables;
    logic [N_IEEE-1:0] flags_new;
    logic [N_IEEE-1:0] hit_enabled;
    logic              unimp;

    assign enables = cur_word[EN_LSB +: N_IEEE];
    assign unimp   = (denorm_in | denorm_out) & ~cur_word[FLUSH_BIT];

    for (genvar i = 0; i < N_IEEE; i++) begin : g_cond
        assign flags_new[i]   = cur_word[FLAG_LSB + i] | (ieee_ind[i] & ~enables[i]);
        assign hit_enabled[i] = ieee_ind[i] & enables[i];
    end

    always_comb begin
        nxt_word                        = cur_word;
        nxt_word[CAUSE_LSB +: N_IEEE]   = ieee_ind;
        nxt_word[UNIMP_BIT]             = unimp;
        nxt_word[FLAG_LSB +: N_IEEE]    = flags_new;
        nxt_word[SUM_BIT]               = |flags_new;
    end

    assign raise = (|hit_enabled) | unimp;
endmodule

// File: rtl/fpsf_word_write.sv
module fpsf_word_write
    import fpsf_pkg::*;
(
    input  logic [WORD_W-1:0] cur_word,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] nxt_word
);
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (b == SUM_BIT) begin : g_sum
            assign nxt_word[b] = |wdata[FLAG_LSB +: N_IEEE];
        end else if (b >= CAUSE_LSB && b < CAUSE_LSB + CAUSE_W) begin : g_cause
            assign nxt_word[b] = cur_word[b] & wdata[b];
        end else begin : g_plain
            assign nxt_word[b] = wdata[b];
        end
    end
endmodule

// File: rtl/fpsf_cond_flags.sv
module fpsf_cond_flags
    import fpsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_is_cmp,
    input  logic [WORD_W-1:0] op_result,
    input  logic [1:0]        cmp_outcome,
    output logic              cond_zero,
    output logic              cond_sign,
    output logic              cond_ovf
);
    cmp_res_e outcome;
    assign outcome = cmp_res_e'(cmp_outcome);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_zero <= 1'b0;
            cond_sign <= 1'b0;
            cond_ovf  <= 1'b0;
        end else if (op_valid) begin
            if (op_is_cmp) begin
                cond_zero <= (outcome == CMP_EQ);
                cond_sign <= (outcome == CMP_LT);
                cond_ovf  <= (outcome == CMP_UN);
            end else begin
                cond_zero <= (op_result[WORD_W-2:0] == '0);
                cond_sign <= op_result[WORD_W-1];
            end
        end
    end

    AST_CMP_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_is_cmp) |-> $onehot0({cond_zero, cond_sign, cond_ovf})); // R8

    AST_ARITH_OVF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && !op_is_cmp) |-> (cond_ovf == $past(cond_ovf))); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(op_valid) |-> $stable({cond_zero, cond_sign, cond_ovf})); // R12
endmodule

// File: rtl/fpsf_unit.sv
module fpsf_unit
    import fpsf_pkg::*;
#(
    parameter int unsigned VEC_W   = 8,
    parameter int unsigned EXC_VEC = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_is_cmp,
    input  logic [31:0]       op_result,
    input  logic [1:0]        cmp_outcome,
    input  logic              ind_invalid,
    input  logic              ind_divzero,
    input  logic              ind_overflow,
    input  logic              ind_underflow,
    input  logic              ind_inexact,
    input  logic              ind_denorm_in,
    input  logic              ind_denorm_out,
    input  logic              sw_wr,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       status_word,
    output logic [1:0]        round_mode,
    output logic              cond_zero,
    output logic              cond_sign,
    output logic              cond_ovf,
    output logic              exc_req,
    output logic [VEC_W-1:0]  exc_vector
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_oper;
    logic [WORD_W-1:0] word_soft;
    logic [N_IEEE-1:0] ieee_ind;
    logic              raise;
    upd_e              sel;

    // index order follows the cause/enable/flag bit order
    assign ieee_ind = {ind_inexact, ind_underflow, ind_divzero, ind_overflow, ind_invalid};

    fpsf_cause_gen u_cause (
        .cur_word   (word_q),
        .ieee_ind   (ieee_ind),
        .denorm_in  (ind_denorm_in),
        .denorm_out (ind_denorm_out),
        .nxt_word   (word_oper),
        .raise      (raise)
    );

    fpsf_word_write u_write (
        .cur_word (word_q),
        .wdata    (sw_wdata),
        .nxt_word (word_soft)
    );

    fpsf_cond_flags u_cond (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_is_cmp   (op_is_cmp),
        .op_result   (op_result),
        .cmp_outcome (cmp_outcome),
        .cond_zero   (cond_zero),
        .cond_sign   (cond_sign),
        .cond_ovf    (cond_ovf)
    );

    always_comb begin
        if (op_valid)   sel = UPD_OPER;
        else if (sw_wr) sel = UPD_SOFT;
        else            sel = UPD_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            exc_req <= 1'b0;
        end else begin
            unique case (sel)
                UPD_OPER: begin
                    word_q  <= word_oper;
                    exc_req <= raise;
                end
                UPD_SOFT: begin
                    word_q  <= word_soft;
                    exc_req <= 1'b0;
                end
                UPD_HOLD: begin
                    exc_req <= 1'b0;
                end
                default: begin
                    exc_req <= 1'b0;
                end
            endcase
        end
    end

    assign status_word = word_q;
    assign round_mode  = word_q[RM_LSB +: RM_W];
    assign exc_vector  = VEC_W'(EXC_VEC);

    AST_REQ_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> $past(op_valid)); // R6

    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> ((status_word[UNIMP_BIT] |
                      |(status_word[CAUSE_LSB +: N_IEEE] & status_word[EN_LSB +: N_IEEE])) == 1'b1)); // R6

    AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[SUM_BIT] == |status_word[FLAG_LSB +: N_IEEE]); // R5

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid) |-> ((status_word[FLAG_LSB +: N_IEEE] & $past(status_word[FLAG_LSB +: N_IEEE]))
                             == $past(status_word[FLAG_LSB +: N_IEEE]))); // R3

    AST_SOFT_NO_NEW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_wr && !op_valid) |-> ((status_word[CAUSE_LSB +: CAUSE_W] &
                                        ~$past(status_word[CAUSE_LSB +: CAUSE_W])) == '0)); // R9

    AST_QUIET_OP_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && (ieee_ind == '0) && !ind_denorm_in && !ind_denorm_out)
        |-> (status_word[CAUSE_LSB +: CAUSE_W] == '0)); // R2
endmodule

// File: tb/tb_fpsf_unit.sv
module tb_fpsf_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_is_cmp = 1'b0;
    logic [31:0] op_result = '0;
    logic [1:0]  cmp_outcome = '0;
    logic        ind_invalid = 1'b0, ind_divzero = 1'b0, ind_overflow = 1'b0;
    logic        ind_underflow = 1'b0, ind_inexact = 1'b0;
    logic        ind_denorm_in = 1'b0, ind_denorm_out = 1'b0;
    logic        sw_wr = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] status_word;
    logic [1:0]  round_mode;
    logic        cond_zero, cond_sign, cond_ovf, exc_req;
    logic [7:0]  exc_vector;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpsf_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_cmp(op_is_cmp),
        .op_result(op_result), .cmp_outcome(cmp_outcome),
        .ind_invalid(ind_invalid), .ind_divzero(ind_divzero), .ind_overflow(ind_overflow),
        .ind_underflow(ind_underflow), .ind_inexact(ind_inexact),
        .ind_denorm_in(ind_denorm_in), .ind_denorm_out(ind_denorm_out),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .status_word(status_word),
        .round_mode(round_mode), .cond_zero(cond_zero), .cond_sign(cond_sign),
        .cond_ovf(cond_ovf), .exc_req(exc_req), .exc_vector(exc_vector)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // ind = {inexact, underflow, divzero, overflow, invalid}; dn = {denorm_out, denorm_in}
    task automatic drive_op(input logic cmp, input logic [31:0] res, input logic [1:0] oc,
                            input logic [4:0] ind, input logic [1:0] dn);
        @(negedge clk);
        op_valid = 1'b1; op_is_cmp = cmp; op_result = res; cmp_outcome = oc;
        {ind_inexact, ind_underflow, ind_divzero, ind_overflow, ind_invalid} = ind;
        {ind_denorm_out, ind_denorm_in} = dn;
        @(negedge clk);
        op_valid = 1'b0; op_is_cmp = 1'b0;
        {ind_inexact, ind_underflow, ind_divzero, ind_overflow, ind_invalid} = '0;
        {ind_denorm_out, ind_denorm_in} = '0;
    endtask

    task automatic sw_write(input logic [31:0] d);
        @(negedge clk);
        sw_wr = 1'b1; sw_wdata = d;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status", status_word, 32'h0);
        chk("R1 round", {30'b0, round_mode}, 32'h0);
        chk("R1 conds", {29'b0, cond_zero, cond_sign, cond_ovf}, 32'h0);
        chk("R1 exc", {31'b0, exc_req}, 32'h0);
    endtask

    task automatic t_soft_write;
        sw_write(32'hFFFF_FFFF);
        chk("R9 write all ones", status_word, 32'hFFFF_FF03);
        chk("R10 round toward -inf", {30'b0, round_mode}, 32'd3);
        chk("R5 summary after write", {31'b0, status_word[31]}, 32'd1);
        sw_write(32'h0000_0001);
        chk("R9 write clears flags", status_word, 32'h0000_0001);
        chk("R10 round toward zero", {30'b0, round_mode}, 32'd1);
    endtask

    task automatic t_arith;
        drive_op(1'b0, 32'h3F80_0000, 2'd0, 5'b10000, 2'b00);
        chk("R2 R3 inexact cause and flag", status_word, 32'hC000_0041);
        chk("R6 no exc when disabled", {31'b0, exc_req}, 32'h0);
        chk("R7 nonzero positive", {29'b0, cond_zero, cond_sign, cond_ovf}, 32'b000);
        drive_op(1'b0, 32'h8000_0000, 2'd0, 5'b00000, 2'b00);
        chk("R2 R3 cause cleared flag kept", status_word, 32'hC000_0001);
        chk("R7 negative zero", {29'b0, cond_zero, cond_sign, cond_ovf}, 32'b110);
        @(negedge clk);
        chk("R12 idle hold word", status_word, 32'hC000_0001);
        chk("R12 idle hold conds", {29'b0, cond_zero, cond_sign, cond_ovf}, 32'b110);
    endtask

    task automatic t_enabled;
        sw_write(32'h0000_0800);
        chk("R9 enable overflow", status_word, 32'h0000_0800);
        drive_op(1'b0, 32'h7F80_0000, 2'd0, 5'b00010, 2'b00);
        chk("R3 enabled cause no flag", status_word, 32'h0000_0808);
        chk("R6 exc raised", {31'b0, exc_req}, 32'd1);
        chk("R6 vector", {24'b0, exc_vector}, 32'd21);
        @(negedge clk);
        chk("R6 exc one cycle", {31'b0, exc_req}, 32'h0);
        sw_write(32'h0000_08FC);
        chk("R9 cause not settable", status_word, 32'h0000_0808);
        sw_write(32'h0000_0800);
        chk("R9 cause clearable", status_word, 32'h0000_0800);
    endtask

    task automatic t_denorm;
        drive_op(1'b0, 32'h0000_0001, 2'd0, 5'b00000, 2'b01);
        chk("R4 unimplemented cause", status_word, 32'h0000_0880);
        chk("R6 unimplemented always enabled", {31'b0, exc_req}, 32'd1);
        sw_write(32'h0000_0900);
        chk("R9 flush on", status_word, 32'h0000_0900);
        drive_op(1'b0, 32'h0000_0001, 2'd0, 5'b00000, 2'b10);
        chk("R4 flush suppresses cause", status_word, 32'h0000_0900);
        chk("R4 no exc under flush", {31'b0, exc_req}, 32'h0);
    endtask

    task automatic t_compare;
        drive_op(1'b1, 32'h0, 2'd1, 5'b00000, 2'b00);
        chk("R8 equal", {29'b0, cond_zero, cond_sign, cond_ovf}, 32'b100);
        drive_op(1'b1, 32'h0, 2'd2, 5'b00000, 2'b00);
        chk("R8 less", {29'b0, cond_zero, cond_sign, cond_ovf}, 32'b010);
        drive_op(1'b1, 32'h0, 2'd3, 5'b00001, 2'b00);
        chk("R8 unordered", {29'b0, cond_zero, cond_sign, cond_ovf}, 32'b001);
        chk("R3 R5 invalid flag", status_word, 32'h8400_0904);
        drive_op(1'b0, 32'h0000_0005, 2'd0, 5'b00000, 2'b00);
        chk("R7 overflow held", {29'b0, cond_zero, cond_sign, cond_ovf}, 32'b001);
        drive_op(1'b1, 32'h0, 2'd0, 5'b00000, 2'b00);
        chk("R8 greater", {29'b0, cond_zero, cond_sign, cond_ovf}, 32'b000);
    endtask

    task automatic t_collision;
        @(negedge clk);
        op_valid = 1'b1; sw_wr = 1'b1; sw_wdata = 32'h0;
        @(negedge clk);
        op_valid = 1'b0; sw_wr = 1'b0;
        chk("R11 write ignored", status_word, 32'h8400_0900);
    endtask

    task automatic t_all_causes;
        sw_write(32'h0000_7C00);
        chk("R9 all enabled", status_word, 32'h0000_7C00);
        drive_op(1'b0, 32'h1234_5678, 2'd0, 5'b11111, 2'b11);
        chk("R2 all causes", status_word, 32'h0000_7CFC);
        chk("R6 exc all causes", {31'b0, exc_req}, 32'd1);
        sw_write(32'h0000_0002);
        chk("R10 round toward +inf", {30'b0, round_mode}, 32'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_soft_write();
        t_arith();
        t_enabled();
        t_denorm();
        t_compare();
        t_collision();
        t_all_causes();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule